// File: doc/BRIEF.md
# Binocular Vergence-Conjugate Gain Datapath

This block is a sampled fixed-point controller for a pair of eyes. Each sample carries two signed retinal error values, one for the left eye and one for the right. The block forms their sum, which measures vergence, and their difference (right minus left), which measures conjugate motion. It scales the sum by a vergence gain and the difference by a conjugate gain. It then produces two drive commands. The conjugate term is subtracted for the left eye and added for the right eye. Both commands share the same sum path and the same difference path.

The block runs at the system clock, but it only acts when a one-cycle `sample_valid` strobe arrives. That strobe comes from a slow sample timer running in the kHz range. A small sequencer has two states:

- `S_IDLE`: waiting for a sample.
- `S_UPDATE`: the held sample is being turned into commands.

Four transitions are defined:

- `T_ARM`: from `S_IDLE` to `S_UPDATE` on a strobe.
- `T_WAIT`: stay in `S_IDLE` with no strobe.
- `T_CHAIN`: stay in `S_UPDATE` on a back-to-back strobe.
- `T_DONE`: from `S_UPDATE` back to `S_IDLE` with no strobe.

The input hold register acts as the sample-and-hold delay stage. A host or a static switch bank loads both gains through a single register-write port.

Top module: `binoc_gain_ctrl`

## Requirements
- R1: A synchronous reset clears both output commands and both gains to zero. After reset, a sample taken without any gain write yields zero on both outputs.
- R2: When `cfg_we` is high, `cfg_data` is stored at the rising edge. It goes to the vergence gain when `cfg_addr` is 0 and to the conjugate gain when `cfg_addr` is 1. Gains are unsigned Q4.8, so 256 means a gain of 1.0.
- R3: The left command equals floor((Gv*(eR+eL) - Gc*(eR-eL)) / 256). Both error inputs are 12-bit two's complement and are combined at full precision.
- R4: The right command equals floor((Gv*(eR+eL) + Gc*(eR-eL)) / 256), computed in the same way.
- R5: Each command saturates to the 16-bit signed range. Values above 32767 give 32767, and values below -32768 give -32768.
- R6: The error inputs are captured at the rising edge where `sample_valid` is high. The commands take their new values at the following rising edge. Changes to the error inputs after the capture edge do not affect that result.
- R7: Between samples both commands hold steady. Changes on the error inputs and gain writes leave them unchanged until the next strobe.
- R8: Strobes on two consecutive cycles are both processed, in order. Each result appears one edge after its own capture edge.
- R9: With `cfg_we` low, activity on `cfg_addr` and `cfg_data` leaves both gains unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe that captures a new error pair |
| err_left | input | 12 | Left retinal error, two's complement |
| err_right | input | 12 | Right retinal error, two's complement |
| cfg_we | input | 1 | Gain write enable |
| cfg_addr | input | 1 | Gain select: 0 vergence, 1 conjugate |
| cfg_data | input | 12 | Gain value, unsigned Q4.8 |
| cmd_left | output | 16 | Left drive command, two's complement, saturated |
| cmd_right | output | 16 | Right drive command, two's complement, saturated |

## Verification
A strobe seen at edge N captures the errors, and both commands change at edge N+1. The bench therefore raises the strobe on a falling edge and looks at the outputs on the next two falling edges. It expects the old value at the first of them and the new value at the second. A gain write takes effect at its own edge and is then used by the next strobe. Hold and ignore checks sample the outputs for several falling edges after the disturbing stimulus, before any further strobe.

// File: rtl/binoc_pkg.sv
package binoc_pkg;

    localparam int ERR_W     = 12;
    localparam int GAIN_W    = 12;
    localparam int GAIN_FRAC = 8;
    localparam int OUT_W     = 16;
    localparam int ADDR_W    = 1;

    localparam int SEL_VERG  = 0;
    localparam int SEL_CONJ  = 1;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_UPDATE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/binoc_seq.sv
module binoc_seq
    import binoc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_valid,
    output logic       cap_en,
    output logic       upd_en,
    output seq_state_e state_q
);

    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cap_en  = sample_valid;
        upd_en  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                // T_ARM / T_WAIT
                state_d = sample_valid ? S_UPDATE : S_IDLE;
            end
            S_UPDATE: begin
                upd_en  = 1'b1;
                // T_CHAIN / T_DONE
                state_d = sample_valid ? S_UPDATE : S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/binoc_gain_regs.sv
module binoc_gain_regs #(
    parameter int GAIN_W = 12,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [GAIN_W-1:0] cfg_data,
    output logic [GAIN_W-1:0] gain_v,
    output logic [GAIN_W-1:0] gain_c
);

    localparam logic [ADDR_W-1:0] ADDR_V = ADDR_W'(binoc_pkg::SEL_VERG);
    localparam logic [ADDR_W-1:0] ADDR_C = ADDR_W'(binoc_pkg::SEL_CONJ);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_v <= '0;
            gain_c <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_V) begin
                gain_v <= cfg_data;
            end
            if (cfg_addr == ADDR_C) begin
                gain_c <= cfg_data;
            end
        end
    end

endmodule

// File: rtl/binoc_err_hold.sv
module binoc_err_hold #(
    parameter int ERR_W = 12,
    localparam int SD_W = ERR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap_en,
    input  logic signed [ERR_W-1:0] err_left,
    input  logic signed [ERR_W-1:0] err_right,
    output logic signed [SD_W-1:0]  err_sum,
    output logic signed [SD_W-1:0]  err_diff
);

    logic signed [ERR_W-1:0] hold_l;
    logic signed [ERR_W-1:0] hold_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (cap_en) begin
            hold_l <= err_left;
            hold_r <= err_right;
        end
    end

    always_comb begin
        err_sum  = SD_W'(hold_r) + SD_W'(hold_l);
        err_diff = SD_W'(hold_r) - SD_W'(hold_l);
    end

endmodule

// File: rtl/binoc_mix.sv
module binoc_mix #(
    parameter int ERR_W     = 12,
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 16,
    parameter bit CONJ_ADD  = 1'b0,
    localparam int SD_W   = ERR_W + 1,
    localparam int PROD_W = SD_W + GAIN_W + 1,
    localparam int ACC_W  = PROD_W + 1,
    localparam int SH_W   = ACC_W - GAIN_FRAC
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_en,
    input  logic signed [SD_W-1:0]  err_sum,
    input  logic signed [SD_W-1:0]  err_diff,
    input  logic [GAIN_W-1:0]       gain_v,
    input  logic [GAIN_W-1:0]       gain_c,
    output logic signed [OUT_W-1:0] cmd_q
);

    localparam logic signed [SH_W-1:0] MAXV =
        {{(SH_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SH_W-1:0] MINV =
        {{(SH_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod_v;
    logic signed [PROD_W-1:0] prod_c;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_sh;
    logic signed [SH_W-1:0]   scaled;
    logic signed [OUT_W-1:0]  cmd_d;

    always_comb begin
        prod_v = PROD_W'(err_sum)  * $signed(PROD_W'({1'b0, gain_v}));
        prod_c = PROD_W'(err_diff) * $signed(PROD_W'({1'b0, gain_c}));
        if (CONJ_ADD) begin
            acc = ACC_W'(prod_v) + ACC_W'(prod_c);
        end else begin
            acc = ACC_W'(prod_v) - ACC_W'(prod_c);
        end
        acc_sh = acc >>> GAIN_FRAC;
        scaled = $signed(acc_sh[SH_W-1:0]);
        if (scaled > MAXV) begin
            cmd_d = MAXV[OUT_W-1:0];
        end else if (scaled < MINV) begin
            cmd_d = MINV[OUT_W-1:0];
        end else begin
            cmd_d = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (upd_en) begin
            cmd_q <= cmd_d;
        end
    end

endmodule

// File: rtl/binoc_gain_ctrl.sv
module binoc_gain_ctrl
    import binoc_pkg::*;
#(
    parameter int P_ERR_W  = binoc_pkg::ERR_W,
    parameter int P_GAIN_W = binoc_pkg::GAIN_W,
    parameter int P_FRAC   = binoc_pkg::GAIN_FRAC,
    parameter int P_OUT_W  = binoc_pkg::OUT_W,
    parameter int P_ADDR_W = binoc_pkg::ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_valid,
    input  logic signed [P_ERR_W-1:0] err_left,
    input  logic signed [P_ERR_W-1:0] err_right,
    input  logic                      cfg_we,
    input  logic [P_ADDR_W-1:0]       cfg_addr,
    input  logic [P_GAIN_W-1:0]       cfg_data,
    output logic signed [P_OUT_W-1:0] cmd_left,
    output logic signed [P_OUT_W-1:0] cmd_right
);

    localparam int SD_W   = P_ERR_W + 1;
    localparam int N_SIDE = 2;

    logic                      cap_en;
    logic                      upd_en;
    seq_state_e                seq_state;
    logic [P_GAIN_W-1:0]       gain_v;
    logic [P_GAIN_W-1:0]       gain_c;
    logic signed [SD_W-1:0]    err_sum;
    logic signed [SD_W-1:0]    err_diff;
    logic signed [P_OUT_W-1:0] side_cmd [N_SIDE];

    binoc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .cap_en       (cap_en),
        .upd_en       (upd_en),
        .state_q      (seq_state)
    );

    binoc_gain_regs #(
        .GAIN_W (P_GAIN_W),
        .ADDR_W (P_ADDR_W)
    ) u_gains (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .gain_v   (gain_v),
        .gain_c   (gain_c)
    );

    binoc_err_hold #(
        .ERR_W (P_ERR_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .err_left  (err_left),
        .err_right (err_right),
        .err_sum   (err_sum),
        .err_diff  (err_diff)
    );

    // side 0 = left (conjugate subtracted), side 1 = right (conjugate added)
    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        binoc_mix #(
            .ERR_W     (P_ERR_W),
            .GAIN_W    (P_GAIN_W),
            .GAIN_FRAC (P_FRAC),
            .OUT_W     (P_OUT_W),
            .CONJ_ADD  (s == 1)
        ) u_mix (
            .clk      (clk),
            .rst      (rst),
            .upd_en   (upd_en),
            .err_sum  (err_sum),
            .err_diff (err_diff),
            .gain_v   (gain_v),
            .gain_c   (gain_c),
            .cmd_q    (side_cmd[s])
        );
    end

    assign cmd_left  = side_cmd[0];
    assign cmd_right = side_cmd[1];

endmodule

// File: rtl/binoc_gain_ctrl_chk.sv
module binoc_gain_ctrl_chk
    import binoc_pkg::*;
#(
    parameter int GAIN_W = 12,
    parameter int ADDR_W = 1,
    parameter int OUT_W  = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      sample_valid,
    input logic                      cfg_we,
    input logic [ADDR_W-1:0]         cfg_addr,
    input logic [GAIN_W-1:0]         cfg_data,
    input logic signed [OUT_W-1:0]   cmd_left,
    input logic signed [OUT_W-1:0]   cmd_right,
    input logic [GAIN_W-1:0]         gain_v,
    input logic [GAIN_W-1:0]         gain_c,
    input seq_state_e                state_q
);

    // R1: first cycle out of reset shows cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_left == '0 && cmd_right == '0));

    // R2: vergence gain write lands
    a_r2_verg_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_W'(SEL_VERG)) |=> (gain_v == $past(cfg_data)));

    // R2: conjugate gain write lands
    a_r2_conj_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_W'(SEL_CONJ)) |=> (gain_c == $past(cfg_data)));

    // R9: no write without enable
    a_r9_no_write: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(gain_v) && $stable(gain_c)));

    // R6: a strobe arms the update state
    a_r6_arm: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> (state_q == S_UPDATE));

    // R7: outputs move only one edge after a strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sample_valid, 2)) |-> ($stable(cmd_left) && $stable(cmd_right)));

endmodule

bind binoc_gain_ctrl binoc_gain_ctrl_chk #(
    .GAIN_W (P_GAIN_W),
    .ADDR_W (P_ADDR_W),
    .OUT_W  (P_OUT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_data     (cfg_data),
    .cmd_left     (cmd_left),
    .cmd_right    (cmd_right),
    .gain_v       (u_gains.gain_v),
    .gain_c       (u_gains.gain_c),
    .state_q      (u_seq.state_q)
);

// File: tb/tb_binoc_gain_ctrl.sv
module tb_binoc_gain_ctrl;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_valid = 1'b0;
    logic signed [11:0] err_left = '0;
    logic signed [11:0] err_right = '0;
    logic               cfg_we = 1'b0;
    logic [0:0]         cfg_addr = '0;
    logic [11:0]        cfg_data = '0;
    logic signed [15:0] cmd_left;
    logic signed [15:0] cmd_right;

    int n_checks = 0;
    int n_errors = 0;
    int gv = 0;
    int gc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    binoc_gain_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .err_left     (err_left),
        .err_right    (err_right),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_data     (cfg_data),
        .cmd_left     (cmd_left),
        .cmd_right    (cmd_right)
    );

    function automatic int model(int g_v, int g_c, int el, int er, bit right);
        longint p;
        longint q;
        p = longint'(g_v) * (er + el);
        if (right) p = p + longint'(g_c) * (er - el);
        else       p = p - longint'(g_c) * (er - el);
        q = p >>> 8;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return int'(q);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_gain(int addr, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'(addr); cfg_data = 12'(val);
        @(negedge clk);
        cfg_we = 1'b0; cfg_data = 12'hA5A;
        if (addr == 0) gv = val; else gc = val;
    endtask

    // one strobe; checks timing (R6) then values
    task automatic sample(string req_l, string req_r, int el, int er);
        int old_l;
        int old_r;
        @(negedge clk);
        old_l = cmd_left; old_r = cmd_right;
        err_left = 12'(el); err_right = 12'(er); sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0; err_left = 12'sh7FF; err_right = -12'sd2048;
        check("R6 not yet left", int'(cmd_left), old_l);
        check("R6 not yet right", int'(cmd_right), old_r);
        @(negedge clk);
        check(req_l, int'(cmd_left), model(gv, gc, el, er, 1'b0));
        check(req_r, int'(cmd_right), model(gv, gc, el, er, 1'b1));
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1 left after reset", int'(cmd_left), 0);
        check("R1 right after reset", int'(cmd_right), 0);
        sample("R1 zero gain left", "R1 zero gain right", 500, -300);
    endtask

    task automatic t_unity_verg();
        write_gain(0, 256);
        sample("R3 verg left", "R4 verg right", 100, 37);
        sample("R3 verg neg left", "R4 verg neg right", -900, -45);
    endtask

    task automatic t_conj_only();
        write_gain(0, 0);
        write_gain(1, 256);
        sample("R3 conj left", "R4 conj right", 40, 300);
        sample("R3 conj left b", "R4 conj right b", -700, 650);
    endtask

    task automatic t_fraction();
        write_gain(0, 128);
        write_gain(1, 384);
        sample("R3 floor left", "R4 floor right", -2, -1);
        sample("R3 mixed left", "R4 mixed right", 1234, -567);
    endtask

    task automatic t_saturate();
        write_gain(0, 4095);
        write_gain(1, 0);
        sample("R5 pos sat left", "R5 pos sat right", 2047, 2047);
        sample("R5 neg sat left", "R5 neg sat right", -2048, -2048);
        write_gain(1, 4095);
        sample("R5 split sat left", "R5 split sat right", -2048, 2047);
    endtask

    task automatic t_hold();
        int l0;
        int r0;
        write_gain(0, 300);
        write_gain(1, 50);
        sample("R3 pre-hold left", "R4 pre-hold right", 321, -123);
        l0 = cmd_left; r0 = cmd_right;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            err_left = 12'(i * 111); err_right = 12'(-i * 77);
        end
        write_gain(0, 1000);
        write_gain(1, 999);
        repeat (3) @(negedge clk);
        check("R7 hold left", int'(cmd_left), l0);
        check("R7 hold right", int'(cmd_right), r0);
    endtask

    task automatic t_no_we();
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 1'b0; cfg_data = 12'd7;
        @(negedge clk);
        cfg_addr = 1'b1; cfg_data = 12'd9;
        @(negedge clk);
        cfg_data = 12'd0;
        // gains must still be 1000 and 999
        sample("R9 left", "R9 right", 15, -20);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        err_left = 12'sd200; err_right = 12'sd10; sample_valid = 1'b1;
        @(negedge clk);
        err_left = -12'sd50; err_right = 12'sd400;
        @(negedge clk);
        sample_valid = 1'b0; err_left = '0; err_right = '0;
        check("R8 first left", int'(cmd_left), model(gv, gc, 200, 10, 1'b0));
        check("R8 first right", int'(cmd_right), model(gv, gc, 200, 10, 1'b1));
        @(negedge clk);
        check("R8 second left", int'(cmd_left), model(gv, gc, -50, 400, 1'b0));
        check("R8 second right", int'(cmd_right), model(gv, gc, -50, 400, 1'b1));
    endtask

    initial begin
        t_reset();
        t_unity_verg();
        t_conj_only();
        t_fraction();
        t_saturate();
        t_hold();
        t_no_we();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule